// File: doc/BRIEF.md
# Interval Timer with Half-Width Register Access

This block is a free-running interval timer whose count and period are twice as wide as the register bus that programs it. Software reaches every full-width quantity through a pair of half-width registers, a low half and a high half. The timer counts up by one each clock while running. When the count equals the programmed period it raises a sticky timeout flag, and it can drive an interrupt line from that flag. Several copies can sit side by side, each with its own interrupt.

Two rules keep the split accesses coherent. A full-width write takes effect only when its high half is written, and it combines that half with the low half written earlier. A read of the live count goes through a holding register that software fills by writing to a count half. A carry between the two half reads therefore cannot tear the value. The timer runs either continuously, wrapping to zero at the period, or in one-shot mode, stopping with the count held at the period.

Top module: `interval_timer`

## Requirements
- R1: While running, the count rises by exactly one per clock, except at the period match. After a stop command the count keeps its value and does not move while stopped.
- R2: A write to the period-low register (address 2) only stages that half. A write to period-high (address 3) commits {written high, staged low} as the new period. Reads of addresses 2 and 3 return the halves of the committed period.
- R3: When the count equals the period while running, the timeout flag is set on that clock. The status register (address 0) reads bit 0 = timeout flag and bit 1 = running.
- R4: In continuous mode, a period match returns the count to zero and the timer keeps running, so the flag sets again on every later match.
- R5: In one-shot mode, a period match clears running, and the count stays at the period value.
- R6: The interrupt output is high exactly when the timeout flag is set and interrupt enable is set. This holds even if the enable is set after the flag.
- R7: Any write to the status register clears the timeout flag and so lowers the interrupt. A match in the same clock wins and sets the flag.
- R8: A write to count-low (address 4) copies the whole live count into a holding register. Reads of addresses 4 (low half) and 5 (high half) return the holding register, which does not change until the next latch.
- R9: A write to count-high (address 5) loads the count with {written high, low half staged by the last count-low write}. It also latches the count value from before the write into the holding register.
- R10: The control register is address 1. Bit 0 is interrupt enable, bit 1 is continuous mode, bit 2 is start and bit 3 is stop, and stop wins over start. A read of address 1 returns bits 1:0, with start and stop reading as zero.
- R11: After reset the timer is stopped. The count, holding register, flag, enable and mode are zero, the period is all ones, and the interrupt is low.
- R12: Addresses 6 and 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (3) | Register address |
| busWrEn | input | 1 | Write strobe, one clock per write |
| busWrData | input | BUS_W (16) | Write data |
| busRdData | output | BUS_W (16) | Read data for busAddr, combinational |
| irq | output | 1 | Timeout interrupt |

## Verification
The bench targets the moment the low half of the count carries into the high half between two half reads. A design that read the live count directly would return a torn value there. It checks that a low-half period write alone leaves the period unchanged; a design that committed each half at once would report the new low half too early. It counts the exact cycle of the continuous-mode wrap and the one-shot stop, which catches a period that is off by one or a timer that keeps running after a one-shot match. It sets the interrupt enable only after the flag is already high, which catches an interrupt wired as a pulse rather than as flag-and-enable.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  localparam int ADDR_STATUS  = 0;
  localparam int ADDR_CONTROL = 1;
  localparam int ADDR_PER_LO  = 2;
  localparam int ADDR_PER_HI  = 3;
  localparam int ADDR_CNT_LO  = 4;
  localparam int ADDR_CNT_HI  = 5;

  localparam int CTL_IRQ_EN = 0;
  localparam int CTL_CONT   = 1;
  localparam int CTL_START  = 2;
  localparam int CTL_STOP   = 3;
  localparam int CTL_BITS   = 4;

  typedef struct packed {
    logic statusWr;
    logic controlWr;
    logic periodLoWr;
    logic periodHiWr;
    logic snapLoWr;
    logic snapHiWr;
  } busStrobes_t;

endpackage

// File: rtl/itimer_ctrl.sv
module itimer_ctrl
  import itimer_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [CTL_BITS-1:0] ctlBits,
  input  logic                atPeriod,
  output busStrobes_t         strb,
  output logic                running,
  output logic                contMode,
  output logic                irqEn,
  output logic                flag,
  output logic                irq
);

  logic matchTick;

  // address decode into single-cycle strobes
  always_comb begin
    strb            = '0;
    strb.statusWr   = busWrEn && (busAddr == ADDR_W'(ADDR_STATUS));
    strb.controlWr  = busWrEn && (busAddr == ADDR_W'(ADDR_CONTROL));
    strb.periodLoWr = busWrEn && (busAddr == ADDR_W'(ADDR_PER_LO));
    strb.periodHiWr = busWrEn && (busAddr == ADDR_W'(ADDR_PER_HI));
    strb.snapLoWr   = busWrEn && (busAddr == ADDR_W'(ADDR_CNT_LO));
    strb.snapHiWr   = busWrEn && (busAddr == ADDR_W'(ADDR_CNT_HI));
  end

  assign matchTick = running && atPeriod;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn    <= 1'b0;
      contMode <= 1'b0;
    end else if (strb.controlWr) begin
      irqEn    <= ctlBits[CTL_IRQ_EN];
      contMode <= ctlBits[CTL_CONT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (strb.controlWr && ctlBits[CTL_STOP]) begin
      running <= 1'b0;
    end else if (strb.controlWr && ctlBits[CTL_START]) begin
      running <= 1'b1;
    end else if (matchTick && !contMode) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (matchTick) begin
      flag <= 1'b1;
    end else if (strb.statusWr) begin
      flag <= 1'b0;
    end
  end

  assign irq = flag && irqEn;

endmodule

// File: rtl/itimer_datapath.sv
module itimer_datapath
  import itimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              running,
  input  logic              contMode,
  input  logic              irqEn,
  input  logic              flag,
  output logic              atPeriod,
  output logic [BUS_W-1:0]  busRdData
);

  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] periodQ;
  logic [CNT_W-1:0] holdQ;
  logic [BUS_W-1:0] perStageQ;
  logic [BUS_W-1:0] cntStageQ;

  assign atPeriod = (countQ == periodQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perStageQ <= '0;
      periodQ   <= '1;
    end else begin
      if (strb.periodLoWr) perStageQ <= busWrData;
      if (strb.periodHiWr) periodQ   <= {busWrData[HI_W-1:0], perStageQ};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntStageQ <= '0;
      holdQ     <= '0;
    end else begin
      if (strb.snapLoWr) cntStageQ <= busWrData;
      if (strb.snapLoWr || strb.snapHiWr) holdQ <= countQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.snapHiWr) begin
      countQ <= {busWrData[HI_W-1:0], cntStageQ};
    end else if (running) begin
      if (atPeriod) begin
        if (contMode) countQ <= '0;
      end else begin
        countQ <= countQ + 1'b1;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_W'(ADDR_STATUS):  busRdData[1:0] = {running, flag};
      ADDR_W'(ADDR_CONTROL): busRdData[1:0] = {contMode, irqEn};
      ADDR_W'(ADDR_PER_LO):  busRdData = periodQ[BUS_W-1:0];
      ADDR_W'(ADDR_PER_HI):  busRdData[HI_W-1:0] = periodQ[CNT_W-1:BUS_W];
      ADDR_W'(ADDR_CNT_LO):  busRdData = holdQ[BUS_W-1:0];
      ADDR_W'(ADDR_CNT_HI):  busRdData[HI_W-1:0] = holdQ[CNT_W-1:BUS_W];
      default:               busRdData = '0;
    endcase
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic              irq
);

  busStrobes_t strb;
  logic running;
  logic contMode;
  logic irqEn;
  logic flag;
  logic atPeriod;

  itimer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .ctlBits  (busWrData[CTL_BITS-1:0]),
    .atPeriod (atPeriod),
    .strb     (strb),
    .running  (running),
    .contMode (contMode),
    .irqEn    (irqEn),
    .flag     (flag),
    .irq      (irq)
  );

  itimer_datapath #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .running   (running),
    .contMode  (contMode),
    .irqEn     (irqEn),
    .flag      (flag),
    .atPeriod  (atPeriod),
    .busRdData (busRdData)
  );

endmodule

// File: rtl/itimer_checker.sv
module itimer_checker
  import itimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             running,
  input logic             contMode,
  input logic             atPeriod,
  input logic             flag,
  input logic             irq,
  input logic [CNT_W-1:0] countQ,
  input busStrobes_t      strb
);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && !atPeriod && !strb.snapHiWr |=> countQ == $past(countQ) + 1'b1);

  // R1
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running && !strb.snapHiWr |=> $stable(countQ));

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && atPeriod |=> flag);

  // R4
  cont_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && atPeriod && contMode && !strb.snapHiWr |=> countQ == '0);

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && atPeriod && !contMode && !strb.controlWr && !strb.snapHiWr
    |=> !running && $stable(countQ));

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.statusWr && !(running && atPeriod) |=> !irq);

endmodule

bind interval_timer itimer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .running  (running),
  .contMode (contMode),
  .atPeriod (atPeriod),
  .flag     (flag),
  .irq      (irq),
  .countQ   (u_dp.countQ),
  .strb     (strb)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        irq;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  interval_timer u_interval_timer (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irq       (irq)
  );

  // entry: {isWrite, addr[2:0], data[15:0], expected[15:0]}
  localparam int NVEC = 16;
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 3'd2, 16'h1234, 16'h0000},
    {1'b0, 3'd2, 16'h0000, 16'hFFFF},
    {1'b1, 3'd3, 16'h0056, 16'h0000},
    {1'b0, 3'd2, 16'h0000, 16'h1234},
    {1'b0, 3'd3, 16'h0000, 16'h0056},
    {1'b1, 3'd1, 16'h0003, 16'h0000},
    {1'b0, 3'd1, 16'h0000, 16'h0003},
    {1'b1, 3'd4, 16'h0010, 16'h0000},
    {1'b0, 3'd4, 16'h0000, 16'h0000},
    {1'b1, 3'd5, 16'h0002, 16'h0000},
    {1'b0, 3'd5, 16'h0000, 16'h0000},
    {1'b1, 3'd4, 16'h0000, 16'h0000},
    {1'b0, 3'd4, 16'h0000, 16'h0010},
    {1'b0, 3'd5, 16'h0000, 16'h0002},
    {1'b1, 3'd7, 16'hBEEF, 16'h0000},
    {1'b0, 3'd7, 16'h0000, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr   = a;
    busWrData = d;
    busWrEn   = 1'b1;
    @(posedge clk);
    #1;
    busWrEn   = 1'b0;
    busWrData = '0;
  endtask

  task automatic readCheck(input string tag, input logic [2:0] a, input logic [15:0] exp);
    busAddr = a;
    #1;
    check(tag, {16'h0, busRdData}, {16'h0, exp});
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #4_000_000;
    testCount++;
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R11 reset state
    check("R11 irq", {31'h0, irq}, 32'h0);
    readCheck("R11 status", 3'd0, 16'h0000);
    readCheck("R11 control", 3'd1, 16'h0000);
    readCheck("R11 period lo", 3'd2, 16'hFFFF);
    readCheck("R11 period hi", 3'd3, 16'hFFFF);
    readCheck("R11 hold lo", 3'd4, 16'h0000);

    // table walk: R2 R8 R9 R10 R12
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][35]) writeReg(VEC[i][34:32], VEC[i][31:16]);
      else readCheck($sformatf("table R2 R8 R9 R10 R12 step %0d", i), VEC[i][34:32], VEC[i][15:0]);
    end
    readCheck("R12 write to unused left status", 3'd0, 16'h0000);

    // continuous mode, period 5, count 0
    writeReg(3'd2, 16'd5);
    writeReg(3'd3, 16'd0);
    writeReg(3'd4, 16'd0);
    writeReg(3'd5, 16'd0);
    writeReg(3'd1, 16'h0007);
    ticks(2);
    writeReg(3'd1, 16'h0008);          // stop; count 3
    readCheck("R10 stop clears running", 3'd0, 16'h0000);
    writeReg(3'd4, 16'h0000);
    readCheck("R1 count after 3 running clocks", 3'd4, 16'd3);
    ticks(5);
    writeReg(3'd4, 16'h0000);
    readCheck("R1 stopped count holds lo", 3'd4, 16'd3);
    readCheck("R1 stopped count holds hi", 3'd5, 16'd0);
    writeReg(3'd1, 16'h0007);          // restart from 3
    ticks(2);
    check("R3 no irq before match", {31'h0, irq}, 32'h0);
    ticks(1);
    check("R6 irq on match", {31'h0, irq}, 32'h1);
    readCheck("R3 status flag and running", 3'd0, 16'h0003);
    writeReg(3'd0, 16'h0000);
    check("R7 status write clears irq", {31'h0, irq}, 32'h0);
    ticks(4);
    check("R4 no irq before second match", {31'h0, irq}, 32'h0);
    ticks(1);
    check("R4 continuous second match", {31'h0, irq}, 32'h1);
    writeReg(3'd1, 16'h0008);
    writeReg(3'd0, 16'h00FF);
    readCheck("R7 nonzero status write clears flag", 3'd0, 16'h0000);

    // one-shot, period 3, interrupt masked
    writeReg(3'd2, 16'd3);
    writeReg(3'd3, 16'd0);
    writeReg(3'd4, 16'd0);
    writeReg(3'd5, 16'd0);
    writeReg(3'd1, 16'h0004);
    ticks(3);
    readCheck("R5 still running before match", 3'd0, 16'h0002);
    ticks(1);
    readCheck("R5 one-shot stopped with flag", 3'd0, 16'h0001);
    check("R6 irq masked", {31'h0, irq}, 32'h0);
    ticks(5);
    writeReg(3'd4, 16'h0000);
    readCheck("R5 count held at period", 3'd4, 16'd3);
    writeReg(3'd1, 16'h0001);
    check("R6 late enable raises irq", {31'h0, irq}, 32'h1);
    writeReg(3'd0, 16'h0000);
    check("R7 clear after late enable", {31'h0, irq}, 32'h0);

    // coherent snapshot across low-half carry
    writeReg(3'd2, 16'hFFFF);
    writeReg(3'd3, 16'hFFFF);
    writeReg(3'd4, 16'hFFFE);
    writeReg(3'd5, 16'h0000);
    writeReg(3'd1, 16'h0006);
    writeReg(3'd4, 16'h0000);
    ticks(3);
    readCheck("R8 latched lo survives carry", 3'd4, 16'hFFFE);
    readCheck("R8 latched hi survives carry", 3'd5, 16'h0000);
    writeReg(3'd4, 16'h0000);
    readCheck("R8 relatch lo", 3'd4, 16'h0002);
    readCheck("R8 relatch hi", 3'd5, 16'h0001);
    writeReg(3'd1, 16'h000C);
    readCheck("R10 stop wins over start", 3'd0, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule